// File: doc/BRIEF.md
# Four-Channel Block-Copy DMA Engine

This block copies blocks of 32-bit words between host memory and an expansion-bus address space. Both spaces are reached through one shared word-wide memory port. Each of four channels owns a 32-byte register window. In that window software sets an external address, a host address, a byte length, a direction, an enable value and a start value.

A channel is launched when a write to its enable or start register leaves both registers equal to 1. The channel then stays busy until its copy ends. The copy engine serves one channel at a time and walks the words in order. Each word takes one read cycle and then one write cycle. When a copy ends, the engine clears the channel's start register and raises a one-cycle completion event. The event code is a base index plus the channel number.

Top module: `xdma_engine`

## Requirements
- R1: After reset every register reads 0, `busy` is 0, and neither `mem_req` nor `evt_valid` is asserted.
- R2: The byte address selects the channel in bits [6:5] and the register in bits [4:2]. The register codes are: 0 external address, 1 host address, 2 size, 3 direction, 4 enable, 5 start, 6 stop. Code 7 is reserved and reads 0. Each register reads back through `reg_rdata` combinationally. Direction reads back as 1 for any nonzero value written and 0 otherwise.
- R3: A channel launches only after a write to its enable or start register leaves both registers equal to 1. From the edge after that write until its completion, the channel's `busy` bit is 1.
- R4: A write to enable or start that leaves enable equal to 1 and start not equal to 1 clears start to 0 and launches nothing. While enable is not 1, a start write is stored as written and launches nothing.
- R5: The size register keeps only bits [28:0] of the written value. The copy moves ceil(size/4) words. A size of 0 completes without any memory access.
- R6: With direction 0, words are read from the host address and written to the external address. With a nonzero direction, words are read from the external address and written to the host address. Both addresses advance by 4 per word.
- R7: Each word uses one read cycle (`mem_req`=1, `mem_we`=0) followed by one write cycle. The write cycle carries `mem_rdata`, which holds the word read one cycle earlier. For W words, the completion event is present in the 1+2W-th cycle after the launching write's clock edge.
- R8: Completion raises `evt_valid` for exactly one cycle with `evt_code` = EVT_BASE + channel. From the next cycle, the channel's start register reads 0 and its `busy` bit is 0.
- R9: Only one channel copies at a time. When the engine becomes free, the lowest-numbered pending channel goes next, whatever the order of the start writes.
- R10: While a channel is busy, writes to its external address, host address, size, direction and start registers are ignored.
- R11: A write to a stop register changes no register, starts nothing and reads back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register byte address, used for both read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data at `reg_addr` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, valid one cycle after a read request |
| busy | output | 4 | Per-channel pending-or-active flag |
| evt_valid | output | 1 | One-cycle completion event |
| evt_code | output | 8 | Event index: base plus channel |

## Verification
A corrupted word counter or address register shows up in memory: words go missing, are duplicated or land at the wrong place. The completion event also moves away from cycle 1+2W, so the cycle count of each transfer exposes the fault within that transfer. A stuck pending flag, or a start register that is not cleared, shows at `busy` or in the start readback one cycle after the event. A wrong arbitration order shows in the sequence of event codes as soon as two channels are pending together.

// File: rtl/xdma_pkg.sv
package xdma_pkg;

    // register code inside a channel window (byte address bits [4:2])
    typedef enum logic [2:0] {
        OFF_EXT  = 3'd0,
        OFF_HOST = 3'd1,
        OFF_SIZE = 3'd2,
        OFF_DIR  = 3'd3,
        OFF_EN   = 3'd4,
        OFF_GO   = 3'd5,
        OFF_HALT = 3'd6,
        OFF_RSVD = 3'd7
    } reg_off_e;

    typedef enum logic [1:0] {
        MV_IDLE,
        MV_RD,
        MV_WR,
        MV_FIN
    } mv_state_e;

    localparam int LEN_W = 29;
    localparam int WCNT_W = LEN_W - 1;

    typedef struct packed {
        logic [31:0]      ext;
        logic [31:0]      host;
        logic [LEN_W-1:0] len;
        logic             dir;
        logic [31:0]      en;
        logic [31:0]      go;
        logic             req;
    } chan_cfg_t;

endpackage

// File: rtl/xdma_regs.sv
module xdma_regs
    import xdma_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int CH_W = $clog2(NCH),
    parameter int AW   = 5 + CH_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [AW-1:0]               addr,
    input  logic [31:0]                 wr_data,
    output logic [31:0]                 rd_data,
    input  logic                        done_vld,
    input  logic [CH_W-1:0]             done_ch,
    output logic [NCH-1:0][31:0]        ext_o,
    output logic [NCH-1:0][31:0]        host_o,
    output logic [NCH-1:0][LEN_W-1:0]   len_o,
    output logic [NCH-1:0]              dir_o,
    output logic [NCH-1:0]              req_o
);

    chan_cfg_t cfg_d [NCH];
    chan_cfg_t cfg_q [NCH];

    logic [CH_W-1:0] sel_ch;
    reg_off_e        sel_off;
    logic [1:0]      unused_addr_lsb;

    assign sel_ch          = addr[AW-1:5];
    assign sel_off         = reg_off_e'(addr[4:2]);
    assign unused_addr_lsb = addr[1:0];

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            cfg_d[i] = cfg_q[i];
            if (done_vld && done_ch == CH_W'(i)) begin
                cfg_d[i].go  = '0;
                cfg_d[i].req = 1'b0;
            end
            if (wr_en && sel_ch == CH_W'(i)) begin
                case (sel_off)
                    OFF_EXT:  if (!cfg_q[i].req) cfg_d[i].ext  = wr_data;
                    OFF_HOST: if (!cfg_q[i].req) cfg_d[i].host = wr_data;
                    OFF_SIZE: if (!cfg_q[i].req) cfg_d[i].len  = wr_data[LEN_W-1:0];
                    OFF_DIR:  if (!cfg_q[i].req) cfg_d[i].dir  = (wr_data != 32'd0);
                    OFF_EN: begin
                        cfg_d[i].en = wr_data;
                        if (!cfg_q[i].req && wr_data == 32'd1) begin
                            if (cfg_q[i].go == 32'd1) cfg_d[i].req = 1'b1;
                            else                      cfg_d[i].go  = '0;
                        end
                    end
                    OFF_GO: begin
                        if (!cfg_q[i].req) begin
                            cfg_d[i].go = wr_data;
                            if (cfg_q[i].en == 32'd1) begin
                                if (wr_data == 32'd1) cfg_d[i].req = 1'b1;
                                else                  cfg_d[i].go  = '0;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) cfg_q[i] <= '0;
        end else begin
            for (int i = 0; i < NCH; i++) cfg_q[i] <= cfg_d[i];
        end
    end

    always_comb begin
        rd_data = '0;
        case (sel_off)
            OFF_EXT:  rd_data = cfg_q[sel_ch].ext;
            OFF_HOST: rd_data = cfg_q[sel_ch].host;
            OFF_SIZE: rd_data = {{(32-LEN_W){1'b0}}, cfg_q[sel_ch].len};
            OFF_DIR:  rd_data = {31'd0, cfg_q[sel_ch].dir};
            OFF_EN:   rd_data = cfg_q[sel_ch].en;
            OFF_GO:   rd_data = cfg_q[sel_ch].go;
            default:  rd_data = '0;
        endcase
    end

    for (genvar g = 0; g < NCH; g++) begin : g_out
        assign ext_o[g]  = cfg_q[g].ext;
        assign host_o[g] = cfg_q[g].host;
        assign len_o[g]  = cfg_q[g].len;
        assign dir_o[g]  = cfg_q[g].dir;
        assign req_o[g]  = cfg_q[g].req;

        // R10
        cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(cfg_q[g].req) && cfg_q[g].req) |->
                $stable({cfg_q[g].ext, cfg_q[g].host, cfg_q[g].len, cfg_q[g].dir}));

        // R8
        go_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (done_vld && done_ch == CH_W'(g)) |=> (cfg_q[g].go == 32'd0 && !cfg_q[g].req));

        // R3
        done_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (done_vld && done_ch == CH_W'(g)) |-> cfg_q[g].req);
    end

endmodule

// File: rtl/xdma_arb.sv
module xdma_arb #(
    parameter int NCH  = 4,
    parameter int CH_W = $clog2(NCH)
) (
    input  logic [NCH-1:0]  req_i,
    input  logic            idle_i,
    output logic            grant_vld_o,
    output logic [CH_W-1:0] grant_ch_o
);

    logic found;

    always_comb begin
        found      = 1'b0;
        grant_ch_o = '0;
        for (int i = 0; i < NCH; i++) begin
            if (req_i[i] && !found) begin
                found      = 1'b1;
                grant_ch_o = CH_W'(i);
            end
        end
        grant_vld_o = found && idle_i;
    end

endmodule

// File: rtl/xdma_mover.sv
module xdma_mover
    import xdma_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int CH_W = $clog2(NCH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      grant_vld,
    input  logic [CH_W-1:0]           grant_ch,
    input  logic [NCH-1:0][31:0]      ext_i,
    input  logic [NCH-1:0][31:0]      host_i,
    input  logic [NCH-1:0][LEN_W-1:0] len_i,
    input  logic [NCH-1:0]            dir_i,
    output logic                      idle_o,
    output logic                      mem_req,
    output logic                      mem_we,
    output logic [31:0]               mem_addr,
    output logic [31:0]               mem_wdata,
    input  logic [31:0]               mem_rdata,
    output logic                      done_vld,
    output logic [CH_W-1:0]           done_ch
);

    typedef struct packed {
        mv_state_e         st;
        logic [CH_W-1:0]   ch;
        logic [31:0]       src;
        logic [31:0]       dst;
        logic [WCNT_W-1:0] left;
    } mv_t;

    mv_t mv_d, mv_q;

    logic [LEN_W:0]    len_round;
    logic [WCNT_W-1:0] words;
    logic [1:0]        unused_round_lsb;

    assign len_round        = {1'b0, len_i[grant_ch]} + (LEN_W+1)'(3);
    assign words            = len_round[LEN_W:2];
    assign unused_round_lsb = len_round[1:0];

    always_comb begin
        mv_d = mv_q;
        case (mv_q.st)
            MV_IDLE: begin
                if (grant_vld) begin
                    mv_d.ch   = grant_ch;
                    mv_d.left = words;
                    mv_d.src  = dir_i[grant_ch] ? ext_i[grant_ch]  : host_i[grant_ch];
                    mv_d.dst  = dir_i[grant_ch] ? host_i[grant_ch] : ext_i[grant_ch];
                    mv_d.st   = (words == '0) ? MV_FIN : MV_RD;
                end
            end
            MV_RD: mv_d.st = MV_WR;
            MV_WR: begin
                mv_d.src  = mv_q.src + 32'd4;
                mv_d.dst  = mv_q.dst + 32'd4;
                mv_d.left = mv_q.left - 1'b1;
                mv_d.st   = (mv_q.left == WCNT_W'(1)) ? MV_FIN : MV_RD;
            end
            default: mv_d.st = MV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mv_q <= '{st: MV_IDLE, default: '0};
        else        mv_q <= mv_d;
    end

    assign idle_o    = (mv_q.st == MV_IDLE);
    assign mem_req   = (mv_q.st == MV_RD) || (mv_q.st == MV_WR);
    assign mem_we    = (mv_q.st == MV_WR);
    assign mem_addr  = (mv_q.st == MV_WR) ? mv_q.dst : mv_q.src;
    assign mem_wdata = mem_rdata;
    assign done_vld  = (mv_q.st == MV_FIN);
    assign done_ch   = mv_q.ch;

    // R7
    wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(mem_req && !mem_we));

    // R8
    evt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_vld |=> !done_vld);

    // R9
    ch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_q.st == MV_RD || mv_q.st == MV_WR) |=> $stable(mv_q.ch));

endmodule

// File: rtl/xdma_engine.sv
module xdma_engine
    import xdma_pkg::*;
#(
    parameter  int NCH      = 4,
    parameter  int EVT_BASE = 16,
    parameter  int EVT_W    = 8,
    localparam int CH_W     = $clog2(NCH),
    localparam int AW       = 5 + CH_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [AW-1:0]    reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic [31:0]      mem_rdata,
    output logic [NCH-1:0]   busy,
    output logic             evt_valid,
    output logic [EVT_W-1:0] evt_code
);

    logic [NCH-1:0][31:0]      ext_w, host_w;
    logic [NCH-1:0][LEN_W-1:0] len_w;
    logic [NCH-1:0]            dir_w, req_w;
    logic                      idle_w, grant_vld_w, done_vld_w;
    logic [CH_W-1:0]           grant_ch_w, done_ch_w;

    xdma_regs #(.NCH(NCH), .CH_W(CH_W), .AW(AW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_we),
        .addr     (reg_addr),
        .wr_data  (reg_wdata),
        .rd_data  (reg_rdata),
        .done_vld (done_vld_w),
        .done_ch  (done_ch_w),
        .ext_o    (ext_w),
        .host_o   (host_w),
        .len_o    (len_w),
        .dir_o    (dir_w),
        .req_o    (req_w)
    );

    xdma_arb #(.NCH(NCH), .CH_W(CH_W)) u_arb (
        .req_i       (req_w),
        .idle_i      (idle_w),
        .grant_vld_o (grant_vld_w),
        .grant_ch_o  (grant_ch_w)
    );

    xdma_mover #(.NCH(NCH), .CH_W(CH_W)) u_mover (
        .clk       (clk),
        .rst_n     (rst_n),
        .grant_vld (grant_vld_w),
        .grant_ch  (grant_ch_w),
        .ext_i     (ext_w),
        .host_i    (host_w),
        .len_i     (len_w),
        .dir_i     (dir_w),
        .idle_o    (idle_w),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .done_vld  (done_vld_w),
        .done_ch   (done_ch_w)
    );

    assign busy      = req_w;
    assign evt_valid = done_vld_w;
    assign evt_code  = EVT_W'(EVT_BASE) + EVT_W'(done_ch_w);

endmodule

// File: tb/tb_xdma_engine.sv
module tb_xdma_engine;

    localparam int BASE = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata;
    logic [3:0]  busy;
    logic        evt_valid;
    logic [7:0]  evt_code;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    xdma_engine dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .busy(busy), .evt_valid(evt_valid), .evt_code(evt_code)
    );

    function automatic logic [31:0] pattern(int i);
        return 32'h5A000000 | (i * 32'h00010203);
    endfunction

    logic [31:0] mem [256];
    logic [31:0] shadow [256];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= pattern(i);
            mem_rdata <= '0;
        end else if (mem_req) begin
            if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[9:2]];
        end
    end

    logic [7:0] evt_log [16];
    int evt_cnt = 0;
    always @(posedge clk) begin
        if (rst_n && evt_valid) begin
            evt_log[evt_cnt[3:0]] <= evt_code;
            evt_cnt <= evt_cnt + 1;
        end
    end

    typedef struct packed {
        logic [1:0]  ch;
        logic        dir;
        logic [31:0] host;
        logic [31:0] ext;
        logic [31:0] len;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{2'd0, 1'b0, 32'h000, 32'h200, 32'd16},
        '{2'd1, 1'b1, 32'h100, 32'h300, 32'd5},
        '{2'd2, 1'b0, 32'h040, 32'h380, 32'hE000_0004},
        '{2'd3, 1'b1, 32'h180, 32'h020, 32'd12},
        '{2'd0, 1'b1, 32'h0C0, 32'h000, 32'd0}
    };

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] ch, logic [2:0] off, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = {ch, off, 2'b00}; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [1:0] ch, logic [2:0] off, output logic [31:0] d);
        reg_addr = {ch, off, 2'b00};
        #1 d = reg_rdata;
    endtask

    task automatic wait_evt(output int n);
        n = 0;
        while (!evt_valid && n < 4000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic shadow_copy(logic dir, logic [31:0] host, logic [31:0] ext, int words);
        for (int k = 0; k < words; k++) begin
            if (dir) shadow[host[9:2] + k] = shadow[ext[9:2] + k];
            else     shadow[ext[9:2] + k]  = shadow[host[9:2] + k];
        end
    endtask

    task automatic mem_cmp(string req);
        int bad = 0;
        int first = -1;
        for (int i = 0; i < 256; i++) begin
            if (mem[i] !== shadow[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        end
        chk(bad == 0, req, (first < 0) ? 32'd0 : mem[first], (first < 0) ? 32'd0 : shadow[first]);
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] r;
        int n, w, e0;
        for (int i = 0; i < 256; i++) shadow[i] = pattern(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(busy == 4'd0, "R1 busy", 32'(busy), 0);
        chk(!mem_req, "R1 mem_req", 32'(mem_req), 0);
        chk(!evt_valid, "R1 evt", 32'(evt_valid), 0);
        rd(2'd1, 3'd5, r); chk(r == 0, "R1 start reg", r, 0);
        rd(2'd3, 3'd0, r); chk(r == 0, "R1 ext reg", r, 0);

        // table walk: R5 R6 R7 R8
        for (int v = 0; v < 5; v++) begin
            wr(VECS[v].ch, 3'd0, VECS[v].ext);
            wr(VECS[v].ch, 3'd1, VECS[v].host);
            wr(VECS[v].ch, 3'd2, VECS[v].len);
            wr(VECS[v].ch, 3'd3, {31'd0, VECS[v].dir});
            wr(VECS[v].ch, 3'd4, 32'd1);
            wr(VECS[v].ch, 3'd5, 32'd1);
            w = int'(({3'b0, VECS[v].len[28:0]} + 32'd3) >> 2);
            wait_evt(n);
            chk(n == 1 + 2 * w, "R7 event cycle", 32'(n), 32'(1 + 2 * w));
            chk(evt_code == 8'(BASE + VECS[v].ch), "R8 event code", 32'(evt_code), 32'(BASE + VECS[v].ch));
            @(negedge clk);
            chk(busy == 4'd0, "R8 busy cleared", 32'(busy), 0);
            rd(VECS[v].ch, 3'd5, r); chk(r == 0, "R8 start cleared", r, 0);
            shadow_copy(VECS[v].dir, VECS[v].host, VECS[v].ext, w);
            mem_cmp("R6 R5 memory after table vector");
        end

        // R5 size masked
        rd(2'd2, 3'd2, r); chk(r == 32'd4, "R5 size mask", r, 4);
        // R2 readback
        rd(2'd1, 3'd3, r); chk(r == 32'd1, "R2 dir readback", r, 1);
        rd(2'd3, 3'd1, r); chk(r == 32'h180, "R2 host readback", r, 32'h180);
        rd(2'd3, 3'd7, r); chk(r == 32'd0, "R2 reserved reads 0", r, 0);

        // R4 cancel with enable=1
        e0 = evt_cnt;
        wr(2'd1, 3'd5, 32'd5);
        rd(2'd1, 3'd5, r); chk(r == 0, "R4 start cancelled", r, 0);
        repeat (6) @(negedge clk);
        chk(busy == 4'd0 && evt_cnt == e0, "R4 no launch", 32'(busy), 0);
        // R4 start held while enable is not 1, then R3 enable write launches
        wr(2'd2, 3'd4, 32'd0);
        wr(2'd2, 3'd5, 32'd1);
        rd(2'd2, 3'd5, r); chk(r == 32'd1, "R4 start kept", r, 1);
        repeat (4) @(negedge clk);
        chk(busy == 4'd0 && evt_cnt == e0, "R4 disabled no launch", 32'(busy), 0);
        wr(2'd2, 3'd4, 32'd1);
        chk(busy == 4'b0100, "R3 busy after enable", 32'(busy), 32'h4);
        wait_evt(n);
        chk(n == 3 && evt_code == 8'(BASE + 2), "R3 launch by enable write", 32'(evt_code), 32'(BASE + 2));
        shadow_copy(1'b0, 32'h040, 32'h380, 1);
        @(negedge clk);

        // R10 and R9: long copy on ch3, pending ch1 then ch0
        wr(2'd3, 3'd0, 32'h200);
        wr(2'd3, 3'd1, 32'h000);
        wr(2'd3, 3'd2, 32'd96);
        wr(2'd3, 3'd3, 32'd0);
        wr(2'd3, 3'd5, 32'd1);
        e0 = evt_cnt;
        wr(2'd3, 3'd0, 32'h3F0);
        wr(2'd3, 3'd5, 32'd0);
        rd(2'd3, 3'd0, r); chk(r == 32'h200, "R10 ext write ignored", r, 32'h200);
        rd(2'd3, 3'd5, r); chk(r == 32'd1, "R10 start write ignored", r, 1);
        wr(2'd1, 3'd0, 32'h280);
        wr(2'd1, 3'd1, 32'h300);
        wr(2'd1, 3'd2, 32'd4);
        wr(2'd1, 3'd3, 32'd0);
        wr(2'd1, 3'd5, 32'd1);
        wr(2'd0, 3'd0, 32'h2C0);
        wr(2'd0, 3'd1, 32'h340);
        wr(2'd0, 3'd2, 32'd8);
        wr(2'd0, 3'd3, 32'd0);
        wr(2'd0, 3'd5, 32'd1);
        chk(busy == 4'b1011 && evt_cnt == e0, "R9 three pending", 32'(busy), 32'hB);
        for (int t = 0; t < 200 && evt_cnt < e0 + 3; t++) @(negedge clk);
        chk(evt_log[e0[3:0]] == 8'(BASE + 3), "R9 first event", 32'(evt_log[e0[3:0]]), BASE + 3);
        chk(evt_log[4'(e0 + 1)] == 8'(BASE + 0), "R9 lowest channel next", 32'(evt_log[4'(e0 + 1)]), BASE);
        chk(evt_log[4'(e0 + 2)] == 8'(BASE + 1), "R9 last event", 32'(evt_log[4'(e0 + 2)]), BASE + 1);
        shadow_copy(1'b0, 32'h000, 32'h200, 24);
        shadow_copy(1'b0, 32'h340, 32'h2C0, 2);
        shadow_copy(1'b0, 32'h300, 32'h280, 1);
        @(negedge clk);
        mem_cmp("R10 R9 memory after queued copies");

        // R11 stop register
        e0 = evt_cnt;
        wr(2'd0, 3'd6, 32'd1);
        rd(2'd0, 3'd6, r); chk(r == 0, "R11 stop reads 0", r, 0);
        rd(2'd0, 3'd0, r); chk(r == 32'h2C0, "R11 ext unchanged", r, 32'h2C0);
        repeat (5) @(negedge clk);
        chk(busy == 4'd0 && evt_cnt == e0, "R11 no launch", 32'(busy), 0);
        mem_cmp("R11 memory unchanged");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule